// File: doc/BRIEF.md
# Strobed parallel-to-serial transmitter

This block turns a parallel word into a serial bit stream after a brief asynchronous, active-low write pulse. The pulse is caught by an asynchronously set capture flop and passed through one flop clocked by the transmit clock. After that, a busy flag rises on the next falling clock edge. On the next rising edge a gate opens for exactly one clock cycle per bit.

While the gate is open, a bit counter steers a one-of-N selector. The serial data line carries the word least significant bit first. The serial clock output is the inverted transmit clock, enabled only during the gated cycles, so a receiver can sample on its rising edges, which fall in the middle of each bit.

The word is not stored inside the block. The sender keeps it stable from the write pulse until the busy flag falls.

Top module: `strobe_serializer`

## Requirements
- R1: While the gate is open, the data line shows `din[i]` in the i-th gated cycle (i = 0 first), so bit 0 leaves first and bit WIDTH-1 last.
- R2: A low pulse on `wr_n` that lies between two clock edges is captured. Let P0 be the first rising edge after the pulse. `busy` rises at the falling edge that follows P0 and not earlier.
- R3: The gate opens on the first rising edge after `busy` rises and stays open for exactly WIDTH clock cycles.
- R4: The bit counter advances only while the gate is open and is back at zero when the gate closes, so each later transfer again begins with bit 0.
- R5: `sdat` is low whenever the gate is closed.
- R6: `sclk` equals the inverted `clk` while the gate is open and is low otherwise, giving exactly WIDTH pulses per transfer.
- R7: `busy` stays high without a break for the whole transfer. It falls at the first falling edge after the gate closes.
- R8: An active-low `rst_n` asynchronously clears the capture flop, the synchronizer, the gate, the counter and `busy`, and holds `busy`, `sdat` and `sclk` low. A transfer cut short by reset does not resume.
- R9: A new write pulse given right after `busy` falls starts a complete new transfer with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Asynchronous write pulse, active low |
| din | input | WIDTH | Parallel word, held stable by the sender |
| busy | output | 1 | Transfer in progress |
| sdat | output | 1 | Serial data, least significant bit first |
| sclk | output | 1 | Gated inverted clock for the receiver |

## Verification
The bound checker watches the following on every rising clock edge:
- The gate only opens while `busy` is high.
- The gate closes only after the counter has reached its last value.
- The counter stays still while the gate is closed.
- `busy` rises only once the synchronizer holds the strobe.
- `busy` falls only once the gate has closed.
- `sdat` is low whenever the block is idle.

Some behaviour can only be shown by the bench's scenarios, which check every half clock period against a reference model:
- the order of bits for several data patterns;
- the exact edges at which `busy` and the gate move;
- the count of `sclk` pulses;
- a transfer started right after the previous one;
- a reset in the middle of a transfer.

// File: rtl/strser_pkg.sv
package strser_pkg;

   localparam int unsigned DEF_WIDTH = 8;

   // Counter width needed to index a word of the given width.
   function automatic int unsigned idx_bits(input int unsigned w);
      return (w < 2) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/strser_strobe_sync.sv
// Captures the asynchronous active-low write pulse and brings it into the
// transmit clock domain through a single flop.
module strser_strobe_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n,
   input  logic gate,
   output logic z1
);

   logic z_q;

   // Set asynchronously by the pulse. Released on a clock edge once the
   // gate is open and the pulse has ended.
   always_ff @(posedge clk or negedge rst_n or negedge wr_n) begin
      if (!rst_n) begin
         z_q <= 1'b0;
      end else if (!wr_n) begin
         z_q <= 1'b1;
      end else if (gate) begin
         z_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z1 <= 1'b0;
      end else begin
         z1 <= z_q;
      end
   end

endmodule

// File: rtl/strser_busy_flag.sv
// Busy flag held in a falling-edge register.
// It rises on the falling edge after the synchronizer has the strobe, and is
// held while either the synchronizer or the gate is still active.
module strser_busy_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic z1,
   input  logic gate,
   output logic busy
);

   logic busy_nx;

   always_comb begin
      busy_nx = z1 | (busy & gate);
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else begin
         busy <= busy_nx;
      end
   end

endmodule

// File: rtl/strser_gate_count.sv
// Gate flop and bit counter. The gate opens one rising edge after busy rises
// and closes after the counter has shown its last index.
module strser_gate_count #(
   parameter int unsigned WIDTH = strser_pkg::DEF_WIDTH,
   localparam int unsigned CNT_W = strser_pkg::idx_bits(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   output logic             gate,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   logic at_last;

   always_comb begin
      at_last = (cnt == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= 1'b0;
      end else begin
         gate <= busy & ~at_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (gate) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/strser_bit_select.sv
// One-of-WIDTH selector built as an AND-OR tree. The output is forced low
// while the gate is closed.
module strser_bit_select #(
   parameter int unsigned WIDTH = strser_pkg::DEF_WIDTH,
   localparam int unsigned CNT_W = strser_pkg::idx_bits(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [CNT_W-1:0] cnt,
   input  logic             en,
   output logic             bit_o
);

   logic [WIDTH-1:0] hit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_term
      assign hit[i] = din[i] & (cnt == CNT_W'(i));
   end

   always_comb begin
      bit_o = en & (|hit);
   end

endmodule

// File: rtl/strobe_serializer.sv
module strobe_serializer #(
   parameter int unsigned WIDTH = strser_pkg::DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic [WIDTH-1:0] din,
   output logic             busy,
   output logic             sdat,
   output logic             sclk
);

   localparam int unsigned CNT_W = strser_pkg::idx_bits(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("strobe_serializer: WIDTH must be at least 2");
   end

   logic             z1_q;
   logic             gate_q;
   logic [CNT_W-1:0] cnt_q;

   strser_strobe_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_n  (wr_n),
      .gate  (gate_q),
      .z1    (z1_q)
   );

   strser_busy_flag u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .z1    (z1_q),
      .gate  (gate_q),
      .busy  (busy)
   );

   strser_gate_count #(.WIDTH(WIDTH)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (busy),
      .gate  (gate_q),
      .cnt   (cnt_q)
   );

   strser_bit_select #(.WIDTH(WIDTH)) u_sel (
      .din   (din),
      .cnt   (cnt_q),
      .en    (gate_q & rst_n),
      .bit_o (sdat)
   );

   always_comb begin
      sclk = ~clk & gate_q;
   end

endmodule

// File: rtl/strobe_serializer_chk.sv
module strobe_serializer_chk #(
   parameter int unsigned WIDTH = strser_pkg::DEF_WIDTH,
   localparam int unsigned CNT_W = strser_pkg::idx_bits(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             gate,
   input logic [CNT_W-1:0] cnt,
   input logic             z1,
   input logic             sdat
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   a_r2_busy_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> z1);

   a_r3_gate_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> busy);

   a_r3_gate_closes_at_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate) |-> $past(cnt) == LAST);

   a_r4_count_still_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> $stable(cnt));

   a_r5_sdat_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sdat);

   a_r7_busy_outlasts_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !gate);

endmodule

bind strobe_serializer strobe_serializer_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .gate  (gate_q),
   .cnt   (cnt_q),
   .z1    (z1_q),
   .sdat  (sdat)
);

// File: tb/strobe_serializer_test.sv
module strobe_serializer_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_n = 1'b1;
   logic [W-1:0] din = '0;
   logic         busy;
   logic         sdat;
   logic         sclk;

   int compared = 0;
   int mismatched = 0;
   int k = -1;        // rising edges since capture; -1 means idle
   bit pend = 1'b0;
   int xfer = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   strobe_serializer #(.WIDTH(W)) uut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_n  (wr_n),
      .din   (din),
      .busy  (busy),
      .sdat  (sdat),
      .sclk  (sclk)
   );

   // Reference model: a phase counter advanced on each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         k = -1;
         pend = 1'b0;
      end else if (pend) begin
         k = 0;
         pend = 1'b0;
      end else if (k >= 0) begin
         k++;
         if (k > W + 1) k = -1;
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string sig);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s at %0t: got %b expected %b", req, sig, $time, act, exp);
      end
   endtask

   task automatic compare(input bit hi);
      bit g_e, b_e, d_e, c_e;
      string tb, td;
      if (!rst_n) begin
         chk(busy, 1'b0, "R8", "busy");
         chk(sdat, 1'b0, "R8", "sdat");
         chk(sclk, 1'b0, "R8", "sclk");
      end else begin
         g_e = (k >= 1 && k <= W);
         b_e = hi ? (k >= 1 && k <= W + 1) : (k >= 0 && k <= W);
         d_e = g_e ? din[k-1] : 1'b0;
         c_e = hi ? 1'b0 : g_e;
         if (k <= 1) tb = (xfer >= 2) ? "R9" : "R2";
         else        tb = (k >= W) ? "R7" : "R3";
         if (!g_e)   td = "R5";
         else        td = (xfer >= 2) ? "R4" : "R1";
         chk(busy, b_e, tb, "busy");
         chk(sdat, d_e, td, "sdat");
         chk(sclk, c_e, "R6", "sclk");
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) compare(1'b1);
   end

   always @(negedge clk) begin
      #2;
      if (!done) compare(1'b0);
   end

   task automatic strobe(input logic [W-1:0] v);
      din = v;
      @(negedge clk);
      #3 wr_n = 1'b0;
      #1 wr_n = 1'b1;
      pend = 1'b1;
      xfer++;
   endtask

   task automatic send(input logic [W-1:0] v);
      strobe(v);
      repeat (W + 3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #3 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      send(8'hA5);   // R1 pattern with mixed bits
      send(8'h00);   // R4: second transfer starts at bit 0
      send(8'hFF);
      send(8'h01);   // R9: strobe right after busy falls
      send(8'h80);
      send(8'h3C);
      // R8: reset in the middle of a transfer
      strobe(8'hC3);
      repeat (4) @(posedge clk);
      @(negedge clk);
      #3 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #3 rst_n = 1'b1;
      repeat (12) @(posedge clk);
      send(8'h5A);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule